// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer Core

This block is a small multicycle processing core. A two-bit state register steps through four phases without end while reset is low: address capture, memory read, instruction load and execute. The core holds a program counter, a memory address register, a memory data register, an instruction register and four operand registers, called W, X, Y and Z. It reads instruction words from an external word-addressed memory that returns data one cycle after the address is shown.

In the execute phase the two top bits of the instruction register select one of four fixed operations on the operand registers. The four operations are a variable left shift of W, a paired update of W and Y, a four-way sum, and a mixed add and subtract. Each one completes in that single execute cycle. The core has no branches and no data-memory writes, so the program counter only moves forward. The core puts its phase and every register on output ports so that they can be observed.

Top module: `fde_core`

## Requirements
- R1: The phase output follows the order 0 (address), 1 (read), 2 (load), 3 (execute) and then returns to 0. It advances one step per clock while reset is low.
- R2: In phase 0, MAR takes the current PC value and PC increases by one (modulo 2^16) on the same clock edge.
- R3: `imem_addr` always equals MAR, and `imem_rd` is high only in phase 1. On the edge that ends phase 1, MDR captures `imem_rdata`.
- R4: On the edge that ends phase 2, IR takes the value of MDR.
- R5: Only IR[15:14] selects the execute operation. IR[13:0] has no effect on any register.
- R6: Opcode 0 writes W shifted left by X into W. When X is 16 or more, W becomes zero.
- R7: Opcode 1 writes W+X into W and Y+Z into Y on the same edge. Both results wrap modulo 2^16.
- R8: Opcode 2 writes W+X+Y+Z, modulo 2^16, into W.
- R9: Opcode 3 writes W+X-Y-Z, modulo 2^16, into W.
- R10: W changes only in phase 3. Y changes only in phase 3 with opcode 1. X and Z never change after reset.
- R11: A synchronous active-high reset puts the phase at 0 and clears PC, MAR, MDR and IR. It loads W, X, Y and Z from the parameter `OPND_RST`, which is all zero by default. Reset takes effect in any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW | Instruction memory word address (MAR) |
| imem_rd | output | 1 | Read strobe, high in the read phase |
| imem_rdata | input | DW | Instruction word returned by memory |
| phase_o | output | 2 | Current phase of the sequencer |
| pc_o | output | AW | Program counter |
| mar_o | output | AW | Memory address register |
| mdr_o | output | DW | Memory data register |
| ir_o | output | DW | Instruction register |
| w_o | output | DW | Operand register W |
| x_o | output | DW | Operand register X |
| y_o | output | DW | Operand register Y |
| z_o | output | DW | Operand register Z |

## Verification
X and Z can never be written, so a shift amount of 16 or more cannot be produced by any program. The bench therefore elaborates a second instance whose reset value for X is 16 and runs a shift instruction on it. Wrap-around in the subtracting opcode needs Y+Z to exceed W+X, so the program mixes shifts that drive W toward zero with later subtracts. A reset is also asserted in the middle of a read phase, which shows that the sequence restarts from phase 0 and that the operands are reloaded.

// File: rtl/fde_pkg.sv
package fde_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_READ = 2'd1,
    PH_LOAD = 2'd2,
    PH_EXEC = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    OP_SHL  = 2'd0,
    OP_PAIR = 2'd1,
    OP_SUM4 = 2'd2,
    OP_MIX  = 2'd3
  } opc_t;

  localparam int NUM_OPND = 4;
  localparam int IDX_W = 0;
  localparam int IDX_X = 1;
  localparam int IDX_Y = 2;
  localparam int IDX_Z = 3;
endpackage

// File: rtl/fde_seq.sv
module fde_seq
  import fde_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase
);
  phase_t phase_nx;

  always_comb begin
    case (phase)
      PH_ADDR: phase_nx = PH_READ;
      PH_READ: phase_nx = PH_LOAD;
      PH_LOAD: phase_nx = PH_EXEC;
      default: phase_nx = PH_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_ADDR;
    else     phase <= phase_nx;
  end
endmodule

// File: rtl/fde_fetch.sv
module fde_fetch
  import fde_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase,
  input  logic [DW-1:0] mem_data,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] ir
);
  localparam logic [AW-1:0] PC_STEP = AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      case (phase)
        PH_ADDR: begin
          mar <= pc;
          pc  <= pc + PC_STEP;
        end
        PH_READ: mdr <= mem_data;
        PH_LOAD: ir  <= mdr;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fde_alu.sv
module fde_alu
  import fde_pkg::*;
#(
  parameter int DW = 16
) (
  input  opc_t          opc,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] z,
  output logic [DW-1:0] w_new,
  output logic [DW-1:0] y_new,
  output logic          y_wr
);
  localparam logic [DW-1:0] SHIFT_LIMIT = DW'(DW);

  logic [DW-1:0] w_shl;
  logic [DW-1:0] sum_wx;
  logic [DW-1:0] sum_yz;

  assign w_shl  = (x >= SHIFT_LIMIT) ? '0 : (w << x);
  assign sum_wx = w + x;
  assign sum_yz = y + z;

  always_comb begin
    y_new = sum_yz;
    y_wr  = 1'b0;
    case (opc)
      OP_SHL:  w_new = w_shl;
      OP_PAIR: begin
        w_new = sum_wx;
        y_wr  = 1'b1;
      end
      OP_SUM4: w_new = sum_wx + sum_yz;
      default: w_new = sum_wx - sum_yz;
    endcase
  end
endmodule

// File: rtl/fde_opnd.sv
module fde_opnd
  import fde_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [NUM_OPND-1:0][DW-1:0] RST_VAL = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_OPND-1:0]          we,
  input  logic [NUM_OPND-1:0][DW-1:0]  d,
  output logic [NUM_OPND-1:0][DW-1:0]  q
);
  for (genvar g = 0; g < NUM_OPND; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[g] <= RST_VAL[g];
      else if (we[g]) q[g] <= d[g];
    end
  end
endmodule

// File: rtl/fde_core.sv
module fde_core
  import fde_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [NUM_OPND-1:0][DW-1:0] OPND_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] imem_addr,
  output logic          imem_rd,
  input  logic [DW-1:0] imem_rdata,
  output logic [1:0]    phase_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] mar_o,
  output logic [DW-1:0] mdr_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] w_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] z_o
);
  localparam int OPC_LSB = DW - 2;

  phase_t phase;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, ir;
  logic [NUM_OPND-1:0][DW-1:0] opnd_q, opnd_d;
  logic [NUM_OPND-1:0] opnd_we;
  logic [DW-1:0] w_new, y_new;
  logic y_wr;
  opc_t opc;

  fde_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  fde_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .mem_data (imem_rdata),
    .pc       (pc),
    .mar      (mar),
    .mdr      (mdr),
    .ir       (ir)
  );

  assign opc = opc_t'(ir[DW-1:OPC_LSB]);

  fde_alu #(.DW(DW)) u_alu (
    .opc   (opc),
    .w     (opnd_q[IDX_W]),
    .x     (opnd_q[IDX_X]),
    .y     (opnd_q[IDX_Y]),
    .z     (opnd_q[IDX_Z]),
    .w_new (w_new),
    .y_new (y_new),
    .y_wr  (y_wr)
  );

  always_comb begin
    opnd_d         = opnd_q;
    opnd_d[IDX_W]  = w_new;
    opnd_d[IDX_Y]  = y_new;
    opnd_we        = '0;
    opnd_we[IDX_W] = (phase == PH_EXEC);
    opnd_we[IDX_Y] = (phase == PH_EXEC) && y_wr;
  end

  fde_opnd #(.DW(DW), .RST_VAL(OPND_RST)) u_opnd (
    .clk (clk),
    .rst (rst),
    .we  (opnd_we),
    .d   (opnd_d),
    .q   (opnd_q)
  );

  assign imem_addr = mar;
  assign imem_rd   = (phase == PH_READ);
  assign phase_o   = phase;
  assign pc_o      = pc;
  assign mar_o     = mar;
  assign mdr_o     = mdr;
  assign ir_o      = ir;
  assign w_o       = opnd_q[IDX_W];
  assign x_o       = opnd_q[IDX_X];
  assign y_o       = opnd_q[IDX_Y];
  assign z_o       = opnd_q[IDX_Z];
endmodule

// File: rtl/fde_core_chk.sv
module fde_core_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] imem_addr,
  input logic          imem_rd,
  input logic [DW-1:0] imem_rdata,
  input logic [1:0]    phase_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] mar_o,
  input logic [DW-1:0] mdr_o,
  input logic [DW-1:0] ir_o,
  input logic [DW-1:0] w_o,
  input logic [DW-1:0] x_o,
  input logic [DW-1:0] y_o,
  input logic [DW-1:0] z_o
);
  logic [1:0] opc;
  assign opc = ir_o[DW-1:DW-2];

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_o == 2'($past(phase_o) + 2'd1));

  assert_addr_capture_R2: assert property (@(posedge clk) disable iff (rst)
    phase_o == 2'd0 |=> (mar_o == $past(pc_o)) && (pc_o == AW'($past(pc_o) + 1'b1)));

  assert_read_capture_R3: assert property (@(posedge clk) disable iff (rst)
    phase_o == 2'd1 |=> mdr_o == $past(imem_rdata));

  assert_read_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    imem_rd |-> (phase_o == 2'd1) && (imem_addr == mar_o));

  assert_ir_load_R4: assert property (@(posedge clk) disable iff (rst)
    phase_o == 2'd2 |=> ir_o == $past(mdr_o));

  assert_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3) && (opc == 2'd1) |=>
      (w_o == DW'($past(w_o) + $past(x_o))) && (y_o == DW'($past(y_o) + $past(z_o))));

  assert_sum4_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3) && (opc == 2'd2) |=>
      w_o == DW'($past(w_o) + $past(x_o) + $past(y_o) + $past(z_o)));

  assert_mix_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3) && (opc == 2'd3) |=>
      w_o == DW'($past(w_o) + $past(x_o) - $past(y_o) - $past(z_o)));

  assert_w_hold_R10: assert property (@(posedge clk) disable iff (rst)
    phase_o != 2'd3 |=> $stable(w_o));

  assert_y_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !((phase_o == 2'd3) && (opc == 2'd1)) |=> $stable(y_o));

  assert_xz_hold_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(x_o) && $stable(z_o));

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (phase_o == 2'd0) && (pc_o == '0) && (ir_o == '0));
endmodule

bind fde_core fde_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_rd    (imem_rd),
  .imem_rdata (imem_rdata),
  .phase_o    (phase_o),
  .pc_o       (pc_o),
  .mar_o      (mar_o),
  .mdr_o      (mdr_o),
  .ir_o       (ir_o),
  .w_o        (w_o),
  .x_o        (x_o),
  .y_o        (y_o),
  .z_o        (z_o)
);

// File: tb/tb_fde_core.sv
module tb_fde_core;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NPROG = 40;
  localparam logic [15:0] W0 = 16'd9, X0 = 16'd3, Y0 = 16'd5, Z0 = 16'd7;
  localparam logic [15:0] BW0 = 16'h1234, BX0 = 16'd16, BY0 = 16'd2, BZ0 = 16'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] mem [64];

  logic [AW-1:0] imem_addr, b_addr;
  logic imem_rd, b_rd;
  logic [DW-1:0] imem_rdata, b_rdata;
  logic [1:0] phase_o, b_phase;
  logic [AW-1:0] pc_o, mar_o, b_pc, b_mar;
  logic [DW-1:0] mdr_o, ir_o, w_o, x_o, y_o, z_o;
  logic [DW-1:0] b_mdr, b_ir, b_w, b_x, b_y, b_z;

  assign imem_rdata = mem[imem_addr[5:0]];
  assign b_rdata    = mem[b_addr[5:0]];

  fde_core #(.AW(AW), .DW(DW), .OPND_RST({Z0, Y0, X0, W0})) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rd(imem_rd),
    .imem_rdata(imem_rdata), .phase_o(phase_o), .pc_o(pc_o), .mar_o(mar_o),
    .mdr_o(mdr_o), .ir_o(ir_o), .w_o(w_o), .x_o(x_o), .y_o(y_o), .z_o(z_o)
  );

  fde_core #(.AW(AW), .DW(DW), .OPND_RST({BZ0, BY0, BX0, BW0})) dut_big (
    .clk(clk), .rst(rst), .imem_addr(b_addr), .imem_rd(b_rd),
    .imem_rdata(b_rdata), .phase_o(b_phase), .pc_o(b_pc), .mar_o(b_mar),
    .mdr_o(b_mdr), .ir_o(b_ir), .w_o(b_w), .x_o(b_x), .y_o(b_y), .z_o(b_z)
  );

  logic [15:0] mw, mx, my, mz;
  logic [15:0] mpc;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd0: return "R6 shift";
      2'd1: return "R7 pair";
      2'd2: return "R8 sum4";
      default: return "R9 mix";
    endcase
  endfunction

  task automatic model_exec(input logic [15:0] instr);
    logic [1:0] op;
    logic [15:0] nw, ny;
    op = instr[15:14];
    ny = my;
    case (op)
      2'd0: nw = (mx >= 16) ? 16'd0 : (mw << mx[3:0]);
      2'd1: begin nw = mw + mx; ny = my + mz; end
      2'd2: nw = mw + mx + my + mz;
      default: nw = mw + mx - my - mz;
    endcase
    mw = nw;
    my = ny;
  endtask

  task automatic model_reset();
    mw = W0; mx = X0; my = Y0; mz = Z0; mpc = 16'd0;
  endtask

  task automatic t_reset_state();
    check(phase_o == 2'd0, "R11 phase", 32'(phase_o), 0);
    check(pc_o == 0 && mar_o == 0, "R11 pc/mar", {pc_o, mar_o}, 0);
    check(mdr_o == 0 && ir_o == 0, "R11 mdr/ir", {mdr_o, ir_o}, 0);
    check({w_o, x_o} == {W0, X0}, "R11 w/x", {w_o, x_o}, {W0, X0});
    check({y_o, z_o} == {Y0, Z0}, "R11 y/z", {y_o, z_o}, {Y0, Z0});
    check(imem_rd == 1'b0, "R3 strobe low in phase 0", 32'(imem_rd), 0);
  endtask

  task automatic t_first_instr();
    step();
    check(phase_o == 2'd1, "R1 phase after 1", 32'(phase_o), 1);
    check(mar_o == 0 && pc_o == 1, "R2 mar/pc", {mar_o, pc_o}, {16'd0, 16'd1});
    check(imem_rd && imem_addr == mar_o, "R3 strobe/addr", {15'd0, imem_rd, imem_addr}, {16'd1, mar_o});
    check(w_o == W0 && y_o == Y0, "R10 hold in phase 1", {w_o, y_o}, {W0, Y0});
    step();
    check(phase_o == 2'd2, "R1 phase after 2", 32'(phase_o), 2);
    check(mdr_o == mem[0], "R3 mdr capture", 32'(mdr_o), 32'(mem[0]));
    check(!imem_rd, "R3 strobe low in phase 2", 32'(imem_rd), 0);
    step();
    check(phase_o == 2'd3, "R1 phase after 3", 32'(phase_o), 3);
    check(ir_o == mem[0], "R4 ir load", 32'(ir_o), 32'(mem[0]));
    check(w_o == W0, "R10 w hold before exec", 32'(w_o), 32'(W0));
    step();
    model_exec(mem[0]);
    mpc = 16'd1;
    check(phase_o == 2'd0, "R1 wrap to 0", 32'(phase_o), 0);
    check(w_o == mw, "R6 shift by X", 32'(w_o), 32'(mw));
    check(b_w == 16'd0, "R6 shift by 16 gives zero", 32'(b_w), 0);
    check(b_y == BY0, "R10 y kept on shift", 32'(b_y), 32'(BY0));
  endtask

  task automatic t_program();
    for (int i = 1; i < NPROG; i++) begin
      logic [15:0] ins;
      ins = mem[i];
      repeat (4) step();
      model_exec(ins);
      mpc = mpc + 16'd1;
      check(pc_o == mpc, "R2 pc advance", 32'(pc_o), 32'(mpc));
      check(ir_o == ins, "R4 ir", 32'(ir_o), 32'(ins));
      check(w_o == mw, {op_tag(ins[15:14]), " w (R5 field)"}, 32'(w_o), 32'(mw));
      check(y_o == my, "R7/R10 y", 32'(y_o), 32'(my));
      check(x_o == X0 && z_o == Z0, "R10 x/z fixed", {x_o, z_o}, {X0, Z0});
    end
  endtask

  task automatic t_low_bits_ignored();
    // Instructions 5 and 9 share opcode 2 but differ in IR[13:0] (R5)
    logic [15:0] a, b;
    a = mem[5]; b = mem[9];
    check(a[15:14] == b[15:14] && a[13:0] != b[13:0], "R5 program setup", {a, b}, {a, b});
  endtask

  task automatic t_mid_reset();
    step();
    check(phase_o == 2'd1, "R1 phase before reset", 32'(phase_o), 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    model_reset();
    check(phase_o == 2'd0 && pc_o == 0, "R11 mid-run reset", {phase_o, pc_o}, 0);
    check(w_o == W0 && y_o == Y0, "R11 operands reloaded", {w_o, y_o}, {W0, Y0});
    repeat (4) step();
    model_exec(mem[0]);
    check(pc_o == 16'd1 && w_o == mw, "R11 restart executes word 0", {pc_o, w_o}, {16'd1, mw});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      logic [1:0] op;
      op = (i == 0) ? 2'd0 : 2'((i * 5 + i / 3) % 4);
      mem[i] = {op, 14'(i * 613 + 5)};
    end
    mem[5] = {2'd2, 14'h0123};
    mem[9] = {2'd2, 14'h3abc};
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_first_instr();
    t_program();
    t_low_bits_ignored();
    t_mid_reset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule